// File: doc/BRIEF.md
# Burst-Read NOR Flash Bus Slave

This block is the device side of a parallel NOR-style flash bus, placed behind the pads of a larger chip. Every bus pin is sampled by the chip's own system clock: the bus clock, the active-low strobes for chip enable, write enable, output enable, address valid and pin reset, a 23-bit address and a 16-bit data input. Edges of the bus clock, write enable and address valid are found by comparing each sample with the one before. Because of this, a write does not depend on whether the bus clock is running. A halted bus clock is simply a run of samples with no rising edge.

Writes are single words. They land either in a small internal word array or, when the top address bit is set, in a command register. The command register selects the read mode (array, identifier or status), the initial burst latency and the burst length. An array read is a synchronous burst that starts at a bus clock edge while address valid is low. After a programmable number of clock edges it streams words, wrapping linearly inside an aligned block of 4, 8 or 16 words.

A burst can be frozen at any point by stopping the bus clock and raising output enable. It continues from the same beat once output enable is lowered and the clock restarts. In place of tristate pins the block drives separate data and enable outputs for the data bus and for the WAIT line.

Top module: `flash_burst_slave`

## Requirements
- R1: After the synchronous reset the block is in array mode with a latency of 3 clock edges, a length of 4 words and every array word zero. With no burst running, WAIT reads asserted (1).
- R2: A rising edge of write enable while chip enable is low, output enable is high, pin reset is high and address valid is low stores the data input at the word addressed by the address pins, when address bit 22 is 0.
- R3: When address valid is high at the write enable rising edge, the write goes to the address latched at the last address-valid rising edge (chip enable low). Bus clock edges during the write change neither the target nor the data.
- R4: A write enable rising edge with output enable low, pin reset low or chip enable high leaves the array unchanged.
- R5: The data output enable is 1 only while chip enable is low, output enable is low, write enable is high and pin reset is high.
- R6: A bus clock rising edge with chip enable low, write enable high and address valid low starts a burst at the pins' address. WAIT stays 1 up to, and deasserts at, the L-th clock edge counted from that starting edge. At that edge the word at the start address appears. L is the latency field, command bits [4:2], and values below 2 act as 2.
- R7: Each further clock edge with address valid high advances one beat. The word index is the start address with its low bits replaced by (start + beat) modulo the length, so the burst wraps inside the aligned block. The length field is command bits [6:5]: 0 selects 4, 1 selects 8, and 2 or 3 select 16.
- R8: With the clock halted and output enable high after data has begun, the data enable is 0, the WAIT enable stays 1, and the current beat and its word are kept. Clock edges after output enable is lowered continue with the next beat.
- R9: A suspend during the initial latency keeps the count of edges already seen, so data still appears after L edges in total.
- R10: The WAIT output enable is the inverse of chip enable and depends on nothing else.
- R11: A command write (address bit 22 = 1) with mode bits [1:0] = 1 makes reads return the identifier word 0x00C5, and mode 2 makes them return 0x0080 (ready bit 7). In both modes WAIT stays 1 throughout.
- R12: Pin reset low ends any burst, including one whose start edge falls in the same sample, and returns the mode to array. It keeps the latency and length settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus pins |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Bus burst clock, sampled level |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| pin_rst_n | input | 1 | Bus-side reset pin, active low |
| addr | input | 23 | Word address; bit 22 selects the command register on writes |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Read data drive enable |
| wait_o | output | 1 | WAIT level, 1 while data is not valid |
| wait_oe | output | 1 | WAIT drive enable |

## Verification
Two of the block's functions can fall in the same sample: the pin reset and a burst-start clock edge with address valid low. The bench drives both in one system clock cycle. It then releases the reset and gives one more clock edge at a latency of 2. A burst wrongly started would show data with WAIT low at that point, while the correct clear leaves WAIT high. The bench also puts suspend and write traffic next to live bursts and checks every beat of every wrap offset against arithmetic index expectations.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int MODE_LSB = 0;
    localparam int LAT_LSB  = 2;
    localparam int LEN_LSB  = 5;
    localparam int CFG_TOP  = 6;

    localparam logic [2:0]  LAT_FLOOR    = 3'd2;
    localparam logic [15:0] STATUS_READY = 16'h0080;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_ID     = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    typedef struct packed {
        rd_mode_e   mode;
        logic [2:0] lat;
        logic [1:0] len_code;
    } bus_cfg_t;

    localparam bus_cfg_t CFG_DEFAULT = '{mode: RM_ARRAY, lat: 3'd3, len_code: 2'd0};

    function automatic logic [3:0] beat_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd3;
            2'd1:    return 4'd7;
            default: return 4'd15;
        endcase
    endfunction

    function automatic logic [2:0] fix_lat(input logic [2:0] l);
        return (l < LAT_FLOOR) ? LAT_FLOOR : l;
    endfunction

    function automatic rd_mode_e decode_mode(input logic [1:0] c);
        case (c)
            2'd1:    return RM_ID;
            2'd2:    return RM_STATUS;
            default: return RM_ARRAY;
        endcase
    endfunction

endpackage

// File: rtl/fbs_edge_det.sv
module fbs_edge_det #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/fbs_cmd_reg.sv
module fbs_cmd_reg import fbs_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output bus_cfg_t          cfg
);
    bus_cfg_t cfg_q;
    logic     unused_hi_bits;

    assign unused_hi_bits = ^wr_data[DATA_W-1:CFG_TOP+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_DEFAULT;
        end else if (pin_clr) begin
            cfg_q.mode <= RM_ARRAY;
        end else if (wr_en) begin
            cfg_q.mode     <= decode_mode(wr_data[MODE_LSB +: 2]);
            cfg_q.lat      <= fix_lat(wr_data[LAT_LSB +: 3]);
            cfg_q.len_code <= wr_data[LEN_LSB +: 2];
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/fbs_burst_seq.sv
module fbs_burst_seq import fbs_pkg::*; #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    input  logic             step,
    input  logic [2:0]       lat,
    input  logic [1:0]       len_code,
    input  logic [IDX_W-1:0] start_idx,
    output logic             active,
    output logic [2:0]       wait_cnt,
    output logic [3:0]       beat,
    output logic [3:0]       mask,
    output logic [IDX_W-1:0] rd_idx
);
    logic             active_q;
    logic [2:0]       cnt_q;
    logic [3:0]       beat_q;
    logic [IDX_W-1:0] base_q;
    logic [IDX_W-1:0] mask_ext;

    assign mask     = beat_mask(len_code);
    assign mask_ext = IDX_W'(mask);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            beat_q   <= '0;
            base_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= lat - 3'd1;
            beat_q   <= '0;
            base_q   <= start_idx;
        end else if (step && active_q) begin
            if (cnt_q != 3'd0) cnt_q  <= cnt_q - 3'd1;
            else               beat_q <= (beat_q + 4'd1) & mask;
        end
    end

    assign active   = active_q;
    assign wait_cnt = cnt_q;
    assign beat     = beat_q;
    assign rd_idx   = (base_q & ~mask_ext) | ((base_q + IDX_W'(beat_q)) & mask_ext);
endmodule

// File: rtl/fbs_array.sv
module fbs_array #(
    parameter int AW     = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/flash_burst_slave.sv
module flash_burst_slave import fbs_pkg::*; #(
    parameter int                ADDR_W  = 23,
    parameter int                DATA_W  = 16,
    parameter int                ARR_AW  = 6,
    parameter logic [DATA_W-1:0] ID_WORD = 16'h00C5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic              pin_rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wait_o,
    output logic              wait_oe
);
    localparam int CMD_BIT = ADDR_W - 1;

    logic [2:0]        rise_vec;
    logic              bclk_rise, we_rise, adv_rise;
    logic [ADDR_W-1:0] addr_lat_q;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_fire, cmd_wr, arr_wr;
    logic              seq_clear, seq_start, seq_step;
    bus_cfg_t          cfg;
    logic [1:0]        cur_mode;
    logic              burst_active;
    logic [2:0]        wait_cnt;
    logic [3:0]        beat, beat_msk;
    logic [ARR_AW-1:0] rd_idx;
    logic [DATA_W-1:0] arr_word;
    logic              unused_addr_bits;

    fbs_edge_det #(.N(3), .RST_VAL(3'b111)) edge_i (
        .clk (clk),
        .rst (rst),
        .lvl ({adv_n, we_n, bus_clk}),
        .rise(rise_vec)
    );

    assign bclk_rise = rise_vec[0];
    assign we_rise   = rise_vec[1];
    assign adv_rise  = rise_vec[2];

    always_ff @(posedge clk) begin
        if (rst)                                             addr_lat_q <= '0;
        else if (!ce_n && (adv_rise || (bclk_rise && !adv_n))) addr_lat_q <= addr;
    end

    assign wr_addr   = adv_n ? addr_lat_q : addr;
    assign wr_fire   = we_rise & ~ce_n & oe_n & pin_rst_n;
    assign cmd_wr    = wr_fire &  wr_addr[CMD_BIT];
    assign arr_wr    = wr_fire & ~wr_addr[CMD_BIT];
    assign unused_addr_bits = ^wr_addr[CMD_BIT-1:ARR_AW];

    assign seq_clear = ~pin_rst_n | (we_rise & ~ce_n);
    assign seq_start = ~ce_n & we_n & ~adv_n & bclk_rise;
    assign seq_step  = ~ce_n & adv_n & bclk_rise;

    fbs_cmd_reg #(.DATA_W(DATA_W)) cmd_i (
        .clk    (clk),
        .rst    (rst),
        .pin_clr(~pin_rst_n),
        .wr_en  (cmd_wr),
        .wr_data(dq_in),
        .cfg    (cfg)
    );

    assign cur_mode = cfg.mode;

    fbs_burst_seq #(.IDX_W(ARR_AW)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (seq_clear),
        .start    (seq_start),
        .step     (seq_step),
        .lat      (cfg.lat),
        .len_code (cfg.len_code),
        .start_idx(addr[ARR_AW-1:0]),
        .active   (burst_active),
        .wait_cnt (wait_cnt),
        .beat     (beat),
        .mask     (beat_msk),
        .rd_idx   (rd_idx)
    );

    fbs_array #(.AW(ARR_AW), .DATA_W(DATA_W)) arr_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (arr_wr),
        .wr_idx (wr_addr[ARR_AW-1:0]),
        .wr_data(dq_in),
        .rd_idx (rd_idx),
        .rd_data(arr_word)
    );

    always_comb begin
        case (cfg.mode)
            RM_ID:     dq_out = ID_WORD;
            RM_STATUS: dq_out = DATA_W'(STATUS_READY);
            default:   dq_out = arr_word;
        endcase
    end

    assign dq_oe   = ~ce_n & ~oe_n & we_n & pin_rst_n;
    assign wait_o  = (cfg.mode != RM_ARRAY) | ~burst_active | (wait_cnt != 3'd0);
    assign wait_oe = ~ce_n;
endmodule

// File: rtl/flash_burst_slave_chk.sv
module flash_burst_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       oe_n,
    input logic       pin_rst_n,
    input logic       dq_oe,
    input logic       wait_o,
    input logic       wait_oe,
    input logic       bclk_rise,
    input logic       we_rise,
    input logic       burst_active,
    input logic [3:0] beat,
    input logic [2:0] wait_cnt,
    input logic [3:0] beat_msk,
    input logic [1:0] mode
);
    // R5
    oe_disable_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    // R10
    wait_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!wait_oe && !dq_oe));

    // R12
    pin_rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_rst_n |=> (!burst_active && mode == 2'd0));

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_rst_n && !bclk_rise && !we_rise) |=> ($stable(beat) && $stable(wait_cnt)));

    // R7
    beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        beat <= beat_msk);

    // R6
    wait_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && $past(mode) == 2'd0 && $fell(wait_o)) |-> $past(bclk_rise));
endmodule

bind flash_burst_slave flash_burst_slave_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .pin_rst_n   (pin_rst_n),
    .dq_oe       (dq_oe),
    .wait_o      (wait_o),
    .wait_oe     (wait_oe),
    .bclk_rise   (bclk_rise),
    .we_rise     (we_rise),
    .burst_active(burst_active),
    .beat        (beat),
    .wait_cnt    (wait_cnt),
    .beat_msk    (beat_msk),
    .mode        (cur_mode)
);

// File: tb/flash_burst_slave_tb_top.sv
`timescale 1ns/1ps
module flash_burst_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_clk = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1, pin_rst_n = 1'b1;
    logic [22:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe, wait_o, wait_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int l_cur  = 3;
    bit done   = 0;

    always #4 clk = ~clk;

    flash_burst_slave dut_i (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .adv_n(adv_n), .pin_rst_n(pin_rst_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o),
        .wait_oe(wait_oe)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'h5A00 + 16'(i * 259);
    endfunction

    function automatic int exp_idx(input int base, input int bt, input int msk);
        return (base & ~msk & 63) | ((base + bt) & msk);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse();
        bus_clk = 1'b1; tick();
        bus_clk = 1'b0; tick();
    endtask

    task automatic wr_direct(input logic [22:0] a, input logic [15:0] d,
                             input logic oe, input logic prst, input logic ce);
        ce_n = ce; oe_n = oe; pin_rst_n = prst; adv_n = 1'b0; addr = a; dq_in = d;
        tick();
        we_n = 1'b0; tick(); tick();
        we_n = 1'b1; tick();
        adv_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; pin_rst_n = 1'b1; tick();
    endtask

    task automatic wr_latched(input logic [22:0] a_lat, input logic [22:0] a_pin, input logic [15:0] d);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a_lat; adv_n = 1'b0; tick();
        adv_n = 1'b1; tick();
        addr = a_pin; dq_in = d;
        pulse(); pulse();
        we_n = 1'b1; tick();
        ce_n = 1'b1; tick();
    endtask

    task automatic cmd(input int mode, input int lat, input int len);
        wr_direct(23'h400000, 16'((len << 5) | (lat << 2) | mode), 1'b1, 1'b1, 1'b0);
        l_cur = (lat < 2) ? 2 : lat;
    endtask

    task automatic burst_start(input int a);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 23'(a); adv_n = 1'b0; tick();
        bus_clk = 1'b1; tick();
        bus_clk = 1'b0; adv_n = 1'b1; tick();
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; tick();
    endtask

    task automatic read_first(input int a, input string req, input logic [15:0] exp);
        burst_start(a);
        repeat (l_cur - 1) pulse();
        chk(req, dq_out, exp);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0; tick();

        // R1 reset state
        ce_n = 1'b0; oe_n = 1'b1; tick();
        chk("R1 wait idle", wait_o, 1);
        chk("R10 wait_oe ce low", wait_oe, 1);
        chk("R5 dq_oe with oe high", dq_oe, 0);
        idle();
        burst_start(5);
        pulse();
        chk("R1 default latency wait", wait_o, 1);
        pulse();
        chk("R1 default latency data wait", wait_o, 0);
        chk("R1 cleared array", dq_out, 0);
        chk("R5 dq_oe driving", dq_oe, 1);
        idle();
        chk("R10 wait_oe ce high", wait_oe, 0);
        chk("R5 dq_oe ce high", dq_oe, 0);

        // R2 fill array with address valid held low
        for (int i = 0; i < 64; i++) wr_direct(23'(i), pat(i), 1'b1, 1'b1, 1'b0);
        cmd(0, 2, 0);
        read_first(33, "R2 readback", pat(33));

        // R6 latency sweep
        for (int lat = 2; lat <= 7; lat++) begin
            cmd(0, lat, 0);
            burst_start(9);
            for (int k = 1; k < lat; k++) begin
                pulse();
                chk("R6 wait level", wait_o, (k < lat - 1) ? 1 : 0);
            end
            chk("R6 first word", dq_out, pat(9));
            idle();
        end
        cmd(0, 0, 0);
        burst_start(14);
        pulse();
        chk("R6 latency floor wait", wait_o, 0);
        chk("R6 latency floor data", dq_out, pat(14));
        idle();

        // R7 wrap sweep
        for (int code = 0; code < 4; code++) begin
            int msk;
            msk = (code == 0) ? 3 : (code == 1) ? 7 : 15;
            cmd(0, 2, code);
            for (int off = 0; off <= msk; off++) begin
                burst_start(16 + off);
                pulse();
                chk("R7 beat0", dq_out, pat(exp_idx(16 + off, 0, msk)));
                for (int b = 1; b < 2 * (msk + 1); b++) begin
                    pulse();
                    chk("R7 wrap beat", dq_out, pat(exp_idx(16 + off, b, msk)));
                end
                idle();
            end
        end

        // R8 suspend after data
        cmd(0, 3, 1);
        burst_start(10);
        pulse(); pulse(); pulse(); pulse();
        chk("R8 pre-suspend beat2", dq_out, pat(exp_idx(10, 2, 7)));
        oe_n = 1'b1;
        repeat (5) tick();
        chk("R8 data disabled", dq_oe, 0);
        chk("R8 wait still driven", wait_oe, 1);
        chk("R8 wait low held", wait_o, 0);
        oe_n = 1'b0; tick();
        chk("R8 beat kept", dq_out, pat(exp_idx(10, 2, 7)));
        pulse();
        chk("R8 resume next beat", dq_out, pat(exp_idx(10, 3, 7)));
        idle();

        // R9 suspend during latency
        cmd(0, 5, 0);
        burst_start(6);
        pulse();
        oe_n = 1'b1;
        repeat (6) tick();
        chk("R9 wait during latency", wait_o, 1);
        chk("R9 wait driven", wait_oe, 1);
        oe_n = 1'b0;
        pulse(); pulse();
        chk("R9 still latency", wait_o, 1);
        pulse();
        chk("R9 data after total", wait_o, 0);
        chk("R9 word", dq_out, pat(6));
        idle();

        // R11 non-array modes
        cmd(1, 2, 0);
        ce_n = 1'b0; oe_n = 1'b0; tick();
        chk("R11 id word", dq_out, 16'h00C5);
        chk("R11 id wait", wait_o, 1);
        burst_start(3); pulse(); pulse();
        chk("R11 id wait after edges", wait_o, 1);
        idle();
        cmd(2, 2, 0);
        ce_n = 1'b0; oe_n = 1'b0; tick();
        chk("R11 status word", dq_out, 16'h0080);
        chk("R11 status wait", wait_o, 1);
        idle();

        // R12 pin reset colliding with a burst start edge
        cmd(1, 2, 0);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 23'd3; adv_n = 1'b0; tick();
        pin_rst_n = 1'b0; bus_clk = 1'b1; tick();
        chk("R12 dq_oe in pin reset", dq_oe, 0);
        pin_rst_n = 1'b1; bus_clk = 1'b0; adv_n = 1'b1; tick();
        pulse();
        chk("R12 no burst started", wait_o, 1);
        idle();
        read_first(3, "R12 array mode, latency kept", pat(3));

        // R3 latched-address write with bus clock running
        wr_latched(23'd7, 23'd40, 16'hBEEF);
        read_first(7, "R3 latched target", 16'hBEEF);
        read_first(40, "R3 pin address ignored", pat(40));

        // R4 rejected writes
        wr_direct(23'd12, 16'h1111, 1'b0, 1'b1, 1'b0);
        read_first(12, "R4 oe low", pat(12));
        wr_direct(23'd12, 16'h2222, 1'b1, 1'b0, 1'b0);
        read_first(12, "R4 pin reset low", pat(12));
        wr_direct(23'd12, 16'h3333, 1'b1, 1'b1, 1'b1);
        read_first(12, "R4 ce high", pat(12));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule